// File: doc/BRIEF.md
# Programmable Parallel Port (Basic Mode)

This block is a three-port parallel I/O peripheral for a processor bus. It offers three 8-bit ports, called A, B and C, plus one command register. Port C is split into an upper and a lower nibble. In the basic mode, A, B, upper C and lower C can each be set to input or output independently. A 2-bit address, an active-low chip select and active-low read and write strobes select the register being accessed. Writes are sampled on the rising clock edge. Read data is combinational and is valid while chip select and read are both low.

The command address accepts two kinds of byte, told apart by bit 7. A configuration byte sets the direction of all four port sections, and it clears the output latch of every section that it makes an output. A single-bit command sets or clears one bit of port C without touching the other bits.

Each port appears on the pins as three separate vectors:
- a live input vector;
- a latch output vector;
- a per-bit output enable.

The surrounding logic builds the tri-state pins from these.

Top module: `ppi_mode0`

## Requirements
- R1: After reset, every section is an input: all output enables are 0 and all output latches are 0.
- R2: A write takes effect at the rising clock edge when cs_n=0 and wr_n=0. Address 0 loads the port A latch, address 1 loads port B, and address 2 loads port C. A latch drives its pins only where its section is an output.
- R3: A write to address 3 with bit 7 = 1 sets the directions, where a 1 means input. Bit 4 controls A, bit 1 controls B, bit 3 controls upper C and bit 0 controls lower C. For example, 0x92 makes A and B inputs and C an output, and 0x90 makes only A an input.
- R4: Such a configuration write clears to 0 the latch of every section it sets as an output. The latch of a section set as input keeps its value.
- R5: A write to address 3 with bit 7 = 0 is a single-bit command. Bits 3..1 give the port C bit index and bit 0 gives the new value. Bits 6..4 are ignored, and no direction or other latch changes. The command also updates a bit in an input half, but that bit stays undriven.
- R6: Reading a port returns the latch for bits in an output section and the live pins for bits in an input section. This applies to each nibble of port C separately.
- R7: A read from address 3 returns 0x00.
- R8: rdata_oe is 1 exactly when cs_n=0 and rd_n=0. Otherwise rdata is 0x00.
- R9: With cs_n=1, a low wr_n changes no latch and no direction.
- R10: When read and write are both active in the same cycle, rdata shows the value from before the edge. The written value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A live pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B live pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C live pins |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
A read and a write can fall in the same cycle, because nothing stops a host from pulling rd_n and wr_n low together. The bench holds cs_n, rd_n and wr_n low together on one address. It samples rdata before the edge and expects the old latch value. After the edge it expects the new value on both the pins and the read bus. The single-bit command is also issued against a half configured as input. The bench then judges the latch and the enables separately, to check that the bit changed and stayed undriven.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PORT_W  = 8;
  localparam int HALF_W  = PORT_W / 2;
  localparam int BIT_IW  = $clog2(PORT_W);
  localparam int HALF_IW = $clog2(HALF_W);

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CMD = 2'd3
  } sel_e;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;
endpackage

// File: rtl/ppi_cmd_dec.sv
module ppi_cmd_dec
  import ppi_pkg::*;
(
  input  logic              wr_fire,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic              mode_ld,
  output dir_t              mode_dir,
  output logic              a_we,
  output logic              b_we,
  output logic              c_we,
  output logic              bsr_we,
  output logic [BIT_IW-1:0] bsr_idx,
  output logic              bsr_val
);
  logic cmd_hit;

  always_comb begin
    cmd_hit        = wr_fire && (sel_e'(addr) == SEL_CMD);
    mode_ld        = cmd_hit && wdata[PORT_W-1];
    bsr_we         = cmd_hit && !wdata[PORT_W-1];
    mode_dir.a_in  = wdata[4];
    mode_dir.b_in  = wdata[1];
    mode_dir.cu_in = wdata[3];
    mode_dir.cl_in = wdata[0];
    bsr_idx        = wdata[BIT_IW:1];
    bsr_val        = wdata[0];
    a_we           = wr_fire && (sel_e'(addr) == SEL_A);
    b_we           = wr_fire && (sel_e'(addr) == SEL_B);
    c_we           = wr_fire && (sel_e'(addr) == SEL_C);
  end
endmodule

// File: rtl/ppi_lane.sv
module ppi_lane #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ld,
  input  logic          mode_in,
  input  logic          data_we,
  input  logic [W-1:0]  data_in,
  input  logic          bit_we,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  q,
  output logic [W-1:0]  oe,
  output logic [W-1:0]  rd_val
);
  logic is_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      is_in <= 1'b1;
    end else if (mode_ld) begin
      is_in <= mode_in;
      if (!mode_in) q <= '0;
    end else if (data_we) begin
      q <= data_in;
    end else if (bit_we) begin
      q[bit_idx] <= bit_val;
    end
  end

  always_comb begin
    oe     = {W{~is_in}};
    rd_val = is_in ? pin_in : q;
  end
endmodule

// File: rtl/ppi_mode0.sv
module ppi_mode0
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  logic              wr_fire;
  logic              mode_ld, a_we, b_we, c_we, bsr_we, bsr_val;
  dir_t              mode_dir;
  logic [BIT_IW-1:0] bsr_idx;
  logic [PORT_W-1:0] a_rd, b_rd, c_rd;

  assign wr_fire = !cs_n && !wr_n;

  ppi_cmd_dec u_dec (
    .wr_fire (wr_fire),
    .addr    (addr),
    .wdata   (wdata),
    .mode_ld (mode_ld),
    .mode_dir(mode_dir),
    .a_we    (a_we),
    .b_we    (b_we),
    .c_we    (c_we),
    .bsr_we  (bsr_we),
    .bsr_idx (bsr_idx),
    .bsr_val (bsr_val)
  );

  ppi_lane #(.W(PORT_W), .IW(BIT_IW)) u_lane_a (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_in(mode_dir.a_in),
    .data_we(a_we), .data_in(wdata), .bit_we(1'b0), .bit_idx('0),
    .bit_val(1'b0), .pin_in(pa_in), .q(pa_out), .oe(pa_oe), .rd_val(a_rd)
  );

  ppi_lane #(.W(PORT_W), .IW(BIT_IW)) u_lane_b (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_in(mode_dir.b_in),
    .data_we(b_we), .data_in(wdata), .bit_we(1'b0), .bit_idx('0),
    .bit_val(1'b0), .pin_in(pb_in), .q(pb_out), .oe(pb_oe), .rd_val(b_rd)
  );

  for (genvar h = 0; h < 2; h++) begin : g_c_half
    logic half_in, half_bit_we;
    assign half_in     = (h == 1) ? mode_dir.cu_in : mode_dir.cl_in;
    assign half_bit_we = bsr_we && (bsr_idx[BIT_IW-1] == 1'(h));

    ppi_lane #(.W(HALF_W), .IW(HALF_IW)) u_lane_c (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_ld(mode_ld),
      .mode_in(half_in),
      .data_we(c_we),
      .data_in(wdata[h*HALF_W +: HALF_W]),
      .bit_we (half_bit_we),
      .bit_idx(bsr_idx[HALF_IW-1:0]),
      .bit_val(bsr_val),
      .pin_in (pc_in[h*HALF_W +: HALF_W]),
      .q      (pc_out[h*HALF_W +: HALF_W]),
      .oe     (pc_oe[h*HALF_W +: HALF_W]),
      .rd_val (c_rd[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    rdata_oe = !cs_n && !rd_n;
    rdata    = '0;
    if (rdata_oe) begin
      unique case (sel_e'(addr))
        SEL_A:   rdata = a_rd;
        SEL_B:   rdata = b_rd;
        SEL_C:   rdata = c_rd;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_mode0_chk.sv
module ppi_mode0_chk
  import ppi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [1:0]        addr,
  input logic [PORT_W-1:0] wdata,
  input logic [PORT_W-1:0] rdata,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pa_oe,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pb_oe,
  input logic [PORT_W-1:0] pc_out,
  input logic [PORT_W-1:0] pc_oe
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
                      pa_out == '0 && pb_out == '0 && pc_out == '0));

  assert_port_a_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'd0) |=> (pa_out == $past(wdata)));

  assert_mode_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'd3 && wdata[7] && !wdata[4]) |=> (pa_out == '0));

  assert_bsr_keeps_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'd3 && !wdata[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
       $stable(pa_out) && $stable(pb_out)));

  assert_cmd_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr == 2'd3) |-> (rdata == '0));

  assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));
endmodule

bind ppi_mode0 ppi_mode0_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .wdata(wdata), .rdata(rdata),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/ppi_mode0_tb.sv
module ppi_mode0_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ppi_mode0 u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    #1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    d = rdata; v = rdata_oe;
    cs_n = 1'b1; rd_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v;
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R8 idle oe", {7'd0, rdata_oe}, 8'h00);
    chk("R8 idle data", rdata, 8'h00);
    pa_in = 8'hC3;
    bus_rd(2'd0, d, v);
    chk("R6 read input A", d, 8'hC3);
    chk("R8 read oe", {7'd0, v}, 8'h01);
  endtask

  task automatic t_mode();
    logic [7:0] d; logic v;
    bus_wr(2'd3, 8'h92);
    chk("R3 0x92 pa_oe", pa_oe, 8'h00);
    chk("R3 0x92 pb_oe", pb_oe, 8'h00);
    chk("R3 0x92 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h5A);
    chk("R2 pa_out", pa_out, 8'h5A);
    chk("R2 pa_oe", pa_oe, 8'hFF);
    bus_rd(2'd0, d, v);
    chk("R6 read output A", d, 8'h5A);
    bus_wr(2'd1, 8'h66);
    bus_wr(2'd3, 8'h90);
    chk("R3 0x90 pa_oe", pa_oe, 8'h00);
    chk("R3 0x90 pb_oe", pb_oe, 8'hFF);
    chk("R4 output B cleared", pb_out, 8'h00);
    chk("R4 input A latch kept", pa_out, 8'h5A);
  endtask

  task automatic t_c_halves();
    logic [7:0] d; logic v;
    bus_wr(2'd3, 8'h88);
    chk("R3 upper C in", pc_oe, 8'h0F);
    bus_wr(2'd2, 8'hA5);
    chk("R2 C latch", pc_out, 8'hA5);
    pc_in = 8'h3C;
    bus_rd(2'd2, d, v);
    chk("R6 split C read", d, 8'h35);
  endtask

  task automatic t_bsr();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd3, 8'h0B);
    chk("R5 set bit5", pc_out, 8'h20);
    bus_wr(2'd3, 8'h0F);
    chk("R5 set bit7", pc_out, 8'hA0);
    bus_wr(2'd3, 8'h7A);
    chk("R5 clear bit5 ignore 6..4", pc_out, 8'h80);
    chk("R5 dir unchanged", pc_oe, 8'hFF);
    chk("R5 A untouched", pa_out, 8'h77);
    bus_wr(2'd3, 8'h89);
    bus_wr(2'd3, 8'h05);
    chk("R5 input half latch", pc_out, 8'h84);
    chk("R5 input half undriven", pc_oe, 8'h00);
  endtask

  task automatic t_ctrl_read_and_cs();
    logic [7:0] d; logic v;
    bus_rd(2'd3, d, v);
    chk("R7 cmd read", d, 8'h00);
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h3E);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'hE1;
    @(negedge clk);
    wr_n = 1'b1;
    #1;
    chk("R9 cs high A", pa_out, 8'h3E);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'd3; wdata = 8'h9B;
    @(negedge clk);
    wr_n = 1'b1;
    #1;
    chk("R9 cs high dir", pa_oe, 8'hFF);
  endtask

  task automatic t_same_cycle();
    bus_wr(2'd0, 8'h11);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'd0; wdata = 8'h22;
    #1;
    chk("R10 old value before edge", rdata, 8'h11);
    @(negedge clk);
    wr_n = 1'b1;
    #1;
    chk("R10 new value after edge", rdata, 8'h22);
    chk("R10 pins after edge", pa_out, 8'h22);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_mode();
    t_c_halves();
    t_bsr();
    t_ctrl_read_and_cs();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule